// File: doc/BRIEF.md
# JTAG Host with Auxiliary Clock on TDI

This block is a JTAG master for one target TAP. It produces TCK from the system clock through a programmable divider. It also drives TMS and TDI and samples TDO, while keeping an internal copy of the target's 16-state TAP controller. Software-side logic or a sequencer issues commands one at a time. A command can be a TAP reset, an instruction-register scan, a data-register scan, or a burst of auxiliary clock pulses. The block answers each command with one response carrying the TDO bits it captured.

Instruction scans choose a register inside the target, and data scans then read or write that register. After a scan the TAP is left parked in Run-Test/Idle. While parked there, TDI is no longer a data line: it becomes a secondary clock for the target's internal flash logic. It toggles once for every TCK cycle spent in that state, so this secondary clock runs at half the TCK rate. For example, a 350 kHz secondary clock needs TCK set to 700 kHz. When the TAP leaves Run-Test/Idle, TDI goes back to carrying scan data.

Top module: `jtag_tclk_host`

## Requirements
- R1: After reset, tck is 0, tms is 1, tdi is 0, busy is 0 and rsp_valid is 0, and the TAP copy is in Test-Logic-Reset.
- R2: Each TCK half-period lasts tck_half+1 system clocks, so a full period lasts 2*(tck_half+1). TMS and TDI change only while TCK is low, and TDO is sampled at the rising TCK edge.
- R3: Opcode 0 (reset) gives exactly 5 TCK cycles with TMS high and leaves the TAP in Test-Logic-Reset.
- R4: Opcode 1 (instruction scan) walks to Shift-IR and shifts cmd_len bits of cmd_data, bit 0 first. TMS is high on the last bit. The scan passes Update-IR and ends in Run-Test/Idle. Starting from Run-Test/Idle it takes cmd_len+6 TCK cycles. Starting from Test-Logic-Reset it takes one more.
- R5: Opcode 2 (data scan) does the same through Shift-DR. It takes cmd_len+5 TCK cycles from Run-Test/Idle and one more from Test-Logic-Reset.
- R6: cmd_len may be any value from 1 to 32. Bit i of rsp_data is the TDO level sampled on the i-th shifted bit, and bits at cmd_len and above read 0.
- R7: Opcode 3 (aux clock) issued in Run-Test/Idle gives 2*cmd_cycles TCK cycles, all in Run-Test/Idle, with TDI toggling once per TCK cycle. It then sets TDI to cmd_level. A count of 0 gives no TCK cycle and only sets the level.
- R8: Opcode 3 issued in Test-Logic-Reset first spends one TCK cycle moving to Run-Test/Idle, with TDI unchanged in that cycle, and then behaves as in R7.
- R9: On each Shift-IR or Shift-DR rising edge, TDI carries the command's data bit for that position. TDI does not toggle while a scan moves out of Run-Test/Idle.
- R10: busy rises on the cycle after a command is accepted (cmd_valid while busy is 0). It falls in the same cycle as a single rsp_valid pulse. A command offered while busy is ignored, and TCK stays low while not busy.
- R11: TDI changes at most once per TCK period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck_half | input | DIV_W | TCK half-period in system clocks, minus one |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 reset, 1 instruction scan, 2 data scan, 3 aux clock |
| cmd_len | input | LEN_W | Scan length in bits, 1 to DATA_W |
| cmd_data | input | DATA_W | Scan data, bit 0 shifted first |
| cmd_cycles | input | CNT_W | Number of full aux clock cycles |
| cmd_level | input | 1 | TDI level left after an aux clock burst |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Captured TDO bits |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Scan data, or aux clock in Run-Test/Idle |
| tdo | input | 1 | Scan data from target |

## Verification
The hardest situation to reach is the hand-over on TDI between its two roles. There are three cases: an aux burst that starts in Test-Logic-Reset, a burst of length zero, and a scan that starts right after a burst left TDI at an arbitrary level. The stimulus chains these commands back to back: a reset, then a burst, then a scan. A behavioural target TAP on the bench tracks TMS independently and records every TDI bit it shifts. It also counts TCK edges and TDI transitions per period, so any leak of the clock role into the shift path, or the reverse, shows up in the recorded bits or the counts.

// File: rtl/jtag_tclk_pkg.sv
package jtag_tclk_pkg;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_e;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IR    = 2'd1,
    OP_DR    = 2'd2,
    OP_TCLK  = 2'd3
  } op_e;

  // Standard TAP controller transition on a rising TCK edge.
  function automatic tap_e tap_next(tap_e s, logic m);
    tap_e n;
    unique case (s)
      TAP_TLR:    n = m ? TAP_TLR    : TAP_RTI;
      TAP_RTI:    n = m ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_DR: n = m ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: n = m ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  n = m ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: n = m ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: n = m ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: n = m ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: n = m ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_IR: n = m ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR: n = m ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  n = m ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: n = m ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: n = m ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: n = m ? TAP_UPD_IR : TAP_SH_IR;
      default:    n = m ? TAP_SEL_DR : TAP_RTI;
    endcase
    return n;
  endfunction

  // TMS value that steers the TAP toward the goal of the command:
  // the matching shift state for scans, Run-Test/Idle otherwise.
  function automatic logic route_tms(tap_e s, op_e op, logic last);
    logic t;
    unique case (s)
      TAP_TLR:    t = 1'b0;
      TAP_RTI:    t = (op == OP_IR) || (op == OP_DR);
      TAP_SEL_DR: t = (op == OP_IR);
      TAP_SEL_IR: t = (op != OP_IR);
      TAP_CAP_DR: t = (op != OP_DR);
      TAP_CAP_IR: t = (op != OP_IR);
      TAP_SH_DR:  t = (op != OP_DR) || last;
      TAP_SH_IR:  t = (op != OP_IR) || last;
      TAP_UPD_DR, TAP_UPD_IR: t = 1'b0;
      default:    t = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/jtag_tap_track.sv
module jtag_tap_track
  import jtag_tclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic tms,
  output tap_e state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= TAP_TLR;
    else if (adv) state <= tap_next(state, tms);
  end
endmodule

// File: rtl/jtag_tclk_host.sv
module jtag_tclk_host
  import jtag_tclk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  tck_half,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [CNT_W-1:0]  cmd_cycles,
  input  logic              cmd_level,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  localparam int         TOG_W   = CNT_W + 1;
  localparam logic [2:0] RST_CYC = 3'd5;

  logic              busy_q, setup_q, rsp_valid_q;
  op_e               op_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [DATA_W-1:0] data_q, rsp_q, data_sh;
  logic [CNT_W-1:0]  cyc_q;
  logic              lvl_q, did_shift_q;
  logic [TOG_W-1:0]  tog_q;
  logic [2:0]        rst_cnt_q;
  logic              tck_q, tms_q, tdi_q;

  // Named internal events, also observed by the checker.
  logic tick, accept, rise_evt, drive_evt, cmd_done, in_shift, last_bit;
  logic tms_nxt, tdi_nxt, in_rti;
  tap_e tap_state;

  assign accept    = cmd_valid && !busy_q;
  assign rise_evt  = busy_q && !setup_q && tick && !tck_q;
  assign drive_evt = setup_q || (busy_q && tick && tck_q);

  jtag_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q && !setup_q),
    .half (tck_half),
    .tick (tick)
  );

  jtag_tap_track u_tap (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (rise_evt),
    .tms  (tms_q),
    .state(tap_state)
  );

  assign in_rti   = (tap_state == TAP_RTI);
  assign data_sh  = data_q >> idx_q;
  assign last_bit = (idx_q == len_q - LEN_W'(1));
  assign in_shift = ((op_q == OP_IR) && (tap_state == TAP_SH_IR)) ||
                    ((op_q == OP_DR) && (tap_state == TAP_SH_DR));

  always_comb begin
    unique case (op_q)
      OP_RESET: cmd_done = (rst_cnt_q == RST_CYC);
      OP_TCLK:  cmd_done = in_rti && (tog_q == {cyc_q, 1'b0});
      default:  cmd_done = in_rti && did_shift_q;
    endcase
  end

  always_comb begin
    tms_nxt = (op_q == OP_RESET) ? 1'b1 : route_tms(tap_state, op_q, last_bit);
    unique case (op_q)
      OP_RESET: tdi_nxt = tdi_q;
      OP_TCLK:  tdi_nxt = tdi_q ^ in_rti;   // aux clock only while parked
      default:  tdi_nxt = data_sh[0];       // data mode
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      setup_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      op_q        <= OP_RESET;
      len_q       <= '0;
      idx_q       <= '0;
      data_q      <= '0;
      rsp_q       <= '0;
      cyc_q       <= '0;
      lvl_q       <= 1'b0;
      did_shift_q <= 1'b0;
      tog_q       <= '0;
      rst_cnt_q   <= '0;
      tck_q       <= 1'b0;
      tms_q       <= 1'b1;
      tdi_q       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        busy_q      <= 1'b1;
        setup_q     <= 1'b1;
        op_q        <= op_e'(cmd_op);
        len_q       <= cmd_len;
        data_q      <= cmd_data;
        cyc_q       <= cmd_cycles;
        lvl_q       <= cmd_level;
        idx_q       <= '0;
        rsp_q       <= '0;
        tog_q       <= '0;
        rst_cnt_q   <= '0;
        did_shift_q <= 1'b0;
      end else begin
        if (drive_evt) begin
          setup_q <= 1'b0;
          tck_q   <= 1'b0;
          if (cmd_done) begin
            busy_q      <= 1'b0;
            rsp_valid_q <= 1'b1;
            if (op_q == OP_TCLK) tdi_q <= lvl_q;
          end else begin
            tms_q <= tms_nxt;
            tdi_q <= tdi_nxt;
            if (op_q == OP_TCLK && in_rti) tog_q <= tog_q + TOG_W'(1);
          end
        end
        if (rise_evt) begin
          tck_q <= 1'b1;
          if (in_shift) begin
            rsp_q       <= rsp_q | (DATA_W'(tdo) << idx_q);
            idx_q       <= idx_q + LEN_W'(1);
            did_shift_q <= 1'b1;
          end
          if (op_q == OP_RESET) rst_cnt_q <= rst_cnt_q + 3'd1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_q;
  assign tck       = tck_q;
  assign tms       = tms_q;
  assign tdi       = tdi_q;
endmodule

// File: rtl/jtag_tclk_host_chk.sv
module jtag_tclk_host_chk
  import jtag_tclk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic busy,
  input logic rsp_valid,
  input op_e  op,
  input tap_e tap_state
);
  // R2
  tms_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> !tck);

  // R2
  tdi_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdi) |-> !tck);

  // R3
  reset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op == OP_RESET) |-> tap_state == TAP_TLR);

  // R4
  scan_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (op == OP_IR || op == OP_DR)) |-> tap_state == TAP_RTI);

  // R7
  aux_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op == OP_TCLK) |-> tap_state == TAP_RTI);

  // R10
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R10
  rsp_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  // R10
  idle_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
endmodule

bind jtag_tclk_host jtag_tclk_host_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tck      (tck_q),
  .tms      (tms_q),
  .tdi      (tdi_q),
  .busy     (busy_q),
  .rsp_valid(rsp_valid_q),
  .op       (op_q),
  .tap_state(tap_state)
);

// File: tb/jtag_tclk_host_tb.sv
`timescale 1ns/1ps
module jtag_tclk_host_tb;
  localparam int DW = 32;
  localparam logic [31:0] IR_CAP = 32'h5A5A_C3C1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  tck_half = 8'd1;
  logic        cmd_valid = 1'b0, cmd_level = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [5:0]  cmd_len = 6'd0;
  logic [31:0] cmd_data = '0;
  logic [15:0] cmd_cycles = '0;
  logic        busy, rsp_valid, tck, tms, tdi, tdo;
  logic [31:0] rsp_data;

  always #2 clk = ~clk;

  jtag_tclk_host u_dut (
    .clk(clk), .rst_n(rst_n), .tck_half(tck_half), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_data(cmd_data), .cmd_cycles(cmd_cycles),
    .cmd_level(cmd_level), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural target TAP: 0 TLR, 1 RTI, 2..8 DR column, 9..15 IR column.
  function automatic int tnext(int s, logic m);
    case (s)
      0: return m ? 0 : 1;
      1: return m ? 2 : 1;
      2: return m ? 9 : 3;
      3: return m ? 5 : 4;
      4: return m ? 5 : 4;
      5: return m ? 8 : 6;
      6: return m ? 7 : 6;
      7: return m ? 8 : 4;
      8: return m ? 2 : 1;
      9: return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  int st = 0, rises = 0, tms_hi = 0, nbits = 0, tdi_chg = 0, per_chg = 0, max_chg = 0;
  logic [63:0] sin = '0;
  logic [31:0] sr = '0, dr_cap = 32'h1234_5678;
  realtime t_prev = 0, t_last = 0;
  bit in_cmd = 0;

  assign tdo = sr[0];

  always @(posedge tck) begin
    rises++;
    if (tms) tms_hi++;
    t_prev = t_last;
    t_last = $realtime;
    if (per_chg > max_chg) max_chg = per_chg;
    per_chg = 0;
    if (st == 4 || st == 11) begin
      if (nbits < 64) sin[nbits] = tdi;
      nbits++;
      sr = sr >> 1;
    end else if (st == 3) sr = dr_cap;
    else if (st == 10) sr = IR_CAP;
    st = tnext(st, tms);
  end

  always @(tdi) if (in_cmd) begin
    tdi_chg++;
    per_chg++;
  end

  typedef struct {
    int op; int len; logic [31:0] data; logic [31:0] rdata;
    int st; int rises; int chg; logic lvl; string tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [31:0] lmask(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  // Monitor: pops one expected item per completion pulse.
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (q.size() == 0) check(1'b0, "R10 unexpected response", 1, 0);
    else begin
      exp_t e;
      e = q.pop_front();
      if (per_chg > max_chg) max_chg = per_chg;
      check(rsp_data == e.rdata, {e.tag, " rsp_data"}, rsp_data, e.rdata);
      check(st == e.st, {e.tag, " final TAP state"}, st, e.st);
      check(rises == e.rises, {e.tag, " TCK cycles"}, rises, e.rises);
      if (e.op == 0) check(tms_hi == 5, "R3 TMS high cycles", tms_hi, 5);
      if (e.op == 1 || e.op == 2) begin
        check(nbits == e.len, "R9 shifted bit count", nbits, e.len);
        check((sin[31:0] & lmask(e.len)) == (e.data & lmask(e.len)),
              "R9 TDI data at shift edges", sin[31:0], e.data & lmask(e.len));
      end
      if (e.op == 3) begin
        check(tdi_chg == e.chg, "R7 TDI transitions", tdi_chg, e.chg);
        check(tdi == e.lvl, "R7 final TDI level", tdi, e.lvl);
        check(max_chg <= 1, "R11 TDI changes per TCK period", max_chg, 1);
      end
      in_cmd = 0;
    end
  end

  // Driver: pushes the expectation, offers the command, waits for completion.
  task automatic issue(input int op, input int len, input logic [31:0] data,
                       input int ncyc, input logic lvl, input int exp_st,
                       input int exp_rises, input string tag, input bit poke);
    exp_t e;
    @(negedge clk);
    e.op = op; e.len = len; e.data = data; e.st = exp_st; e.rises = exp_rises;
    e.lvl = lvl; e.tag = tag;
    e.rdata = (op == 1) ? (IR_CAP & lmask(len)) : (op == 2) ? (dr_cap & lmask(len)) : 32'h0;
    e.chg = 2 * ncyc + ((lvl != tdi) ? 1 : 0);
    q.push_back(e);
    rises = 0; tms_hi = 0; nbits = 0; sin = '0; tdi_chg = 0; per_chg = 0; max_chg = 0;
    in_cmd = 1;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_len = 6'(len); cmd_data = data;
    cmd_cycles = 16'(ncyc); cmd_level = lvl;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (poke) begin
      cmd_valid = 1'b1; cmd_op = 2'd0;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (in_cmd) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && tck == 1'b0, "R10 idle after response", {busy, tck}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tck == 0 && tms == 1 && tdi == 0 && busy == 0 && rsp_valid == 0,
          "R1 reset outputs", {tck, tms, tdi, busy, rsp_valid}, 5'b01000);

    issue(0, 0, 32'h0, 0, 1'b0, 0, 5, "R3 reset", 0);
    issue(1, 4, 32'h0000_000A, 0, 1'b0, 1, 11, "R4 IR scan from TLR", 0);
    dr_cap = 32'h1234_5678;
    issue(2, 32, 32'hDEAD_BEEF, 0, 1'b0, 1, 37, "R6 R5 DR scan len 32", 0);
    dr_cap = 32'hFFFF_FFFF;
    issue(2, 1, 32'h0000_0001, 0, 1'b0, 1, 6, "R6 DR scan len 1", 0);
    issue(3, 0, 32'h0, 3, 1'b1, 1, 6, "R7 aux clock N=3", 0);
    issue(3, 0, 32'h0, 0, 1'b0, 1, 0, "R7 aux clock N=0", 0);
    issue(1, 8, 32'h0000_00C5, 0, 1'b0, 1, 14, "R9 IR scan after aux", 0);
    issue(0, 0, 32'h0, 0, 1'b0, 0, 5, "R3 reset again", 0);
    issue(3, 0, 32'h0, 2, 1'b1, 1, 5, "R8 aux clock from TLR", 0);
    dr_cap = 32'hA5C3_0F96;
    issue(2, 12, 32'h0000_0B3D, 0, 1'b0, 1, 17, "R10 DR scan with ignored offer", 1);
    tck_half = 8'd3;
    issue(2, 5, 32'h0000_0013, 0, 1'b0, 1, 10, "R2 DR scan slow TCK", 0);
    check((t_last - t_prev) == 32.0, "R2 TCK period", longint'(t_last - t_prev), 32);
    check(q.size() == 0, "R10 pending responses", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule